// File: doc/BRIEF.md
# Pause Frame Transmit Scheduler

This block decides when flow-control pause frames leave a MAC transmit path and produces them. It watches nine request slots: slots 0 to 7 ask for a per-priority pause on the matching traffic class, and slot 8 asks for a link-wide global pause. Each slot has a 16-bit quanta value, a 16-bit refresh interval and an enable bit. Each of the two frame kinds has its own header fields: destination address, source address, ethertype and opcode.

When at least one enabled slot is pending and no user frame is in flight, the scheduler stages a complete 60-byte control frame, without the FCS, and streams it on a valid/ready bus with a last flag. When the frame has been sent it reports which slots the frame covered. A pending global request is served before priority requests. All pending priorities are merged into one frame. A per-slot refresh timer re-arms a slot so the pause repeats while its request stays high. A one-cycle resend strobe clears every timer and makes all active requests pending again at once.

Top module: `pause_tx_sched`

## Requirements
- R1: While reset is held and after it is released with no requests, `tx_valid` and `slot_sent` are 0.
- R2: A global frame (slot 8) is 60 bytes padded to eight 64-bit beats, numbered from 0. Byte k of the frame sits in beat k/8 at bits [8*(k%8)+7 : 8*(k%8)]. Bytes 0-5 hold the global destination address, bytes 6-11 the source address, bytes 12-13 the ethertype and bytes 14-15 the opcode. Bytes 16-17 hold the slot-8 quanta. Every multi-byte field is sent most significant byte first. All other bytes are zero. `tx_last` is high only on beat 7.
- R3: A priority frame uses the priority header fields in bytes 0-15 and covers every priority slot pending at its start. Byte 16 is 0 and byte 17 is the class-enable mask, with bit p set for each included priority p. Bytes 18+2p and 19+2p hold the quanta of priority p, most significant byte first, or zero when p is not included. All other bytes up to 63 are zero.
- R4: A slot is pending only while both its request and its enable bit are 1. A slot whose enable bit is 0 never appears in any frame or in `slot_sent`.
- R5: A frame starts on a clock edge only if `user_busy` is low at that edge. While `user_busy` stays high, `tx_valid` stays low.
- R6: If slot 8 and any priority slot are pending together, the global frame is sent first and the priority frame follows it. A global frame never covers a priority slot.
- R7: `slot_sent` pulses for exactly one cycle, in the cycle after the final beat is accepted. Its bits are the slots the frame covered.
- R8: Let R be a slot's refresh value. If the slot's request stays high, the slot becomes pending again R+2 cycles after the cycle in which its final beat was accepted. This holds for R = 0 as well.
- R9: A one-cycle `resend` pulse clears every refresh timer and makes every slot whose request and enable are both high pending on the next edge. The frame in flight is not affected.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold steady. Once a frame has started, it runs to its last beat whatever `user_busy` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_req | input | 9 | Pause request per slot; bit 8 is global |
| slot_en | input | 9 | Transmit enable per slot |
| resend | input | 1 | One-cycle strobe: clear timers, re-send active requests |
| slot_quanta | input | 144 | Quanta of slot i in bits [16i+15:16i] |
| slot_refresh | input | 9*TMR_W | Refresh interval of slot i in bits [TMR_W*i +: TMR_W] |
| glb_da | input | 48 | Global frame destination address |
| glb_sa | input | 48 | Global frame source address |
| glb_etype | input | 16 | Global frame ethertype |
| glb_opcode | input | 16 | Global frame opcode |
| pri_da | input | 48 | Priority frame destination address |
| pri_sa | input | 48 | Priority frame source address |
| pri_etype | input | 16 | Priority frame ethertype |
| pri_opcode | input | 16 | Priority frame opcode |
| user_busy | input | 1 | High while a user frame is in flight |
| tx_ready | input | 1 | Downstream accepts the current beat |
| tx_valid | output | 1 | Beat valid |
| tx_data | output | DATA_W | Frame beat |
| tx_last | output | 1 | Final beat of the frame |
| slot_sent | output | 9 | One-cycle pulse of slots covered by the frame just sent |

## Verification
The bench targets the following corner cases, and each would expose a specific design error.

- Simultaneous global and priority requests. A design with the order reversed, or one that folds the priorities into the global frame, would emit the wrong `slot_sent` sequence.
- A priority with its request high but its enable low. A design that ignores the enable would put that priority's bit in the class mask and fill its quanta field.
- A zero refresh interval, and a `resend` pulse in the middle of a long interval. An off-by-one reload, or a timer that ignores the strobe, shifts or removes frames that the reference model predicts to the cycle.
- Irregular backpressure while `user_busy` toggles. A design that drops data under stall, or that starts a frame during a user frame, would be caught.

// File: rtl/pause_tx_pkg.sv
package pause_tx_pkg;
   localparam int PT_NPRI    = 8;
   localparam int PT_NSLOT   = PT_NPRI + 1;
   localparam int PT_GSLOT   = PT_NPRI;
   localparam int PT_QW      = 16;
   localparam int PT_ADDR_W  = 48;
   localparam int PT_FIELD_W = 16;
   localparam int PT_FBYTES  = 64;
   localparam int PT_FB      = PT_FBYTES * 8;

   typedef enum logic {TX_IDLE, TX_SEND} pt_state_e;
endpackage

// File: rtl/pause_slot_track.sv
module pause_slot_track #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             resend,
   input  logic             done,
   input  logic             covered,
   input  logic [TMR_W-1:0] refresh,
   output logic             pend
);
   logic             run;
   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         run  <= 1'b0;
         cnt  <= '0;
      end else if (resend) begin
         pend <= act;
         run  <= 1'b0;
         cnt  <= '0;
      end else if (done && covered) begin
         pend <= 1'b0;
         run  <= 1'b1;
         cnt  <= refresh;
      end else begin
         pend <= act & (pend | ~run);
         if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - TMR_W'(1);
         end
      end
   end

   // R4: a pending slot had request and enable high at the previous edge
   p_pend_needs_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> $past(act));

   // R8: a slot re-arms only after its timer has run out, unless resend forced it
   p_rearm_after_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> ($past(resend) || !$past(run)));
endmodule

// File: rtl/pause_frame_build.sv
module pause_frame_build
   import pause_tx_pkg::*;
(
   input  logic                      sel_glb,
   input  logic [PT_NPRI-1:0]        pri_mask,
   input  logic [PT_NSLOT*PT_QW-1:0] quanta,
   input  logic [PT_ADDR_W-1:0]      glb_da,
   input  logic [PT_ADDR_W-1:0]      glb_sa,
   input  logic [PT_FIELD_W-1:0]     glb_etype,
   input  logic [PT_FIELD_W-1:0]     glb_opcode,
   input  logic [PT_ADDR_W-1:0]      pri_da,
   input  logic [PT_ADDR_W-1:0]      pri_sa,
   input  logic [PT_FIELD_W-1:0]     pri_etype,
   input  logic [PT_FIELD_W-1:0]     pri_opcode,
   output logic [PT_FB-1:0]          frame
);
   localparam int NAB = PT_ADDR_W / 8;

   logic [PT_ADDR_W-1:0]  da, sa;
   logic [PT_FIELD_W-1:0] et, op;

   always_comb begin
      da = sel_glb ? glb_da     : pri_da;
      sa = sel_glb ? glb_sa     : pri_sa;
      et = sel_glb ? glb_etype  : pri_etype;
      op = sel_glb ? glb_opcode : pri_opcode;
      frame = '0;
      for (int k = 0; k < NAB; k++) begin
         frame[8*k +: 8]       = da[8*(NAB-1-k) +: 8];
         frame[8*(k+NAB) +: 8] = sa[8*(NAB-1-k) +: 8];
      end
      frame[8*12 +: 8] = et[15:8];
      frame[8*13 +: 8] = et[7:0];
      frame[8*14 +: 8] = op[15:8];
      frame[8*15 +: 8] = op[7:0];
      if (sel_glb) begin
         frame[8*16 +: 8] = quanta[PT_GSLOT*PT_QW + 8 +: 8];
         frame[8*17 +: 8] = quanta[PT_GSLOT*PT_QW +: 8];
      end else begin
         frame[8*17 +: 8] = pri_mask;
         for (int p = 0; p < PT_NPRI; p++) begin
            if (pri_mask[p]) begin
               frame[8*(18+2*p) +: 8] = quanta[p*PT_QW + 8 +: 8];
               frame[8*(19+2*p) +: 8] = quanta[p*PT_QW +: 8];
            end
         end
      end
   end
endmodule

// File: rtl/pause_tx_fsm.sv
module pause_tx_fsm
   import pause_tx_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                user_busy,
   input  logic                start_ok,
   input  logic [PT_NSLOT-1:0] cov_next,
   input  logic [PT_FB-1:0]    frame_next,
   input  logic                tx_ready,
   output logic                tx_valid,
   output logic [DATA_W-1:0]   tx_data,
   output logic                tx_last,
   output logic                done,
   output logic [PT_NSLOT-1:0] cov,
   output logic [PT_NSLOT-1:0] sent
);
   localparam int NBEAT = PT_FB / DATA_W;

   pt_state_e          state;
   logic [PT_FB-1:0]   frame_q;
   logic               start;

   assign start    = (state == TX_IDLE) && !user_busy && start_ok;
   assign tx_valid = (state == TX_SEND);
   assign done     = tx_valid && tx_ready && tx_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TX_IDLE;
         frame_q <= '0;
         cov     <= '0;
         sent    <= '0;
      end else begin
         sent <= done ? cov : '0;
         if (start) begin
            state   <= TX_SEND;
            frame_q <= frame_next;
            cov     <= cov_next;
         end else if (done) begin
            state <= TX_IDLE;
         end
      end
   end

   generate
      if (NBEAT == 1) begin : g_single
         assign tx_last = tx_valid;
         assign tx_data = frame_q;
      end else begin : g_multi
         localparam int BW = $clog2(NBEAT);
         logic [BW-1:0] beat;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 beat <= '0;
            else if (start)             beat <= '0;
            else if (tx_valid && tx_ready) beat <= beat + BW'(1);
         end
         assign tx_last = tx_valid && (beat == BW'(NBEAT-1));
         assign tx_data = frame_q[beat*DATA_W +: DATA_W];
      end
   endgenerate

   p_hold_under_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   p_no_start_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_valid && user_busy) |=> !tx_valid);

   p_sent_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|sent) |=> (sent == '0));

   p_sent_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> (|sent));

   p_global_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sent[PT_GSLOT] |-> (sent[PT_NPRI-1:0] == '0));
endmodule

// File: rtl/pause_tx_sched.sv
module pause_tx_sched
   import pause_tx_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int TMR_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PT_NSLOT-1:0]         slot_req,
   input  logic [PT_NSLOT-1:0]         slot_en,
   input  logic                        resend,
   input  logic [PT_NSLOT*PT_QW-1:0]   slot_quanta,
   input  logic [PT_NSLOT*TMR_W-1:0]   slot_refresh,
   input  logic [PT_ADDR_W-1:0]        glb_da,
   input  logic [PT_ADDR_W-1:0]        glb_sa,
   input  logic [PT_FIELD_W-1:0]       glb_etype,
   input  logic [PT_FIELD_W-1:0]       glb_opcode,
   input  logic [PT_ADDR_W-1:0]        pri_da,
   input  logic [PT_ADDR_W-1:0]        pri_sa,
   input  logic [PT_FIELD_W-1:0]       pri_etype,
   input  logic [PT_FIELD_W-1:0]       pri_opcode,
   input  logic                        user_busy,
   input  logic                        tx_ready,
   output logic                        tx_valid,
   output logic [DATA_W-1:0]           tx_data,
   output logic                        tx_last,
   output logic [PT_NSLOT-1:0]         slot_sent
);
   generate
      if (DATA_W < 8 || DATA_W > PT_FB || (DATA_W % 8) != 0 || (PT_FB % DATA_W) != 0) begin : g_bad_width
         $error("pause_tx_sched: DATA_W must be a byte multiple dividing %0d", PT_FB);
      end
      if (TMR_W < 1 || TMR_W > 32) begin : g_bad_timer
         $error("pause_tx_sched: TMR_W out of range");
      end
   endgenerate

   logic [PT_NSLOT-1:0] act, pend, cov, cov_next;
   logic [PT_NPRI-1:0]  pri_p;
   logic                glb_p, start_ok, done;
   logic [PT_FB-1:0]    frame_next;

   assign act      = slot_req & slot_en;
   assign glb_p    = pend[PT_GSLOT] & act[PT_GSLOT];
   assign pri_p    = pend[PT_NPRI-1:0] & act[PT_NPRI-1:0];
   assign start_ok = glb_p | (|pri_p);
   assign cov_next = glb_p ? {1'b1, {PT_NPRI{1'b0}}} : {1'b0, pri_p};

   genvar gi;
   generate
      for (gi = 0; gi < PT_NSLOT; gi++) begin : g_slot
         pause_slot_track #(.TMR_W(TMR_W)) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .act     (act[gi]),
            .resend  (resend),
            .done    (done),
            .covered (cov[gi]),
            .refresh (slot_refresh[gi*TMR_W +: TMR_W]),
            .pend    (pend[gi])
         );
      end
   endgenerate

   pause_frame_build u_build (
      .sel_glb    (glb_p),
      .pri_mask   (pri_p),
      .quanta     (slot_quanta),
      .glb_da     (glb_da),
      .glb_sa     (glb_sa),
      .glb_etype  (glb_etype),
      .glb_opcode (glb_opcode),
      .pri_da     (pri_da),
      .pri_sa     (pri_sa),
      .pri_etype  (pri_etype),
      .pri_opcode (pri_opcode),
      .frame      (frame_next)
   );

   pause_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .user_busy  (user_busy),
      .start_ok   (start_ok),
      .cov_next   (cov_next),
      .frame_next (frame_next),
      .tx_ready   (tx_ready),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_last    (tx_last),
      .done       (done),
      .cov        (cov),
      .sent       (slot_sent)
   );

   // R4: no reported slot may have had its enable low while the frame was built
   p_sent_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !$past(tx_valid)) |-> ((cov & ~$past(slot_en)) == '0));
endmodule

// File: tb/pause_tx_sched_test.sv
module pause_tx_sched_test;
   localparam int DW = 64;
   localparam int TW = 16;
   localparam int NB = 512 / DW;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst_n = 1'b0;
   logic [8:0]      slot_req = '0, slot_en = 9'h1FF;
   logic            resend = 1'b0, user_busy = 1'b0, tx_ready = 1'b1;
   logic [15:0]     q [9];
   logic [TW-1:0]   rf [9];
   logic [143:0]    slot_quanta;
   logic [9*TW-1:0] slot_refresh;
   logic [47:0]     glb_da = 48'h0180C2000001, glb_sa = 48'h00AABBCCDDEE;
   logic [47:0]     pri_da = 48'h0180C2000001, pri_sa = 48'h001122334455;
   logic [15:0]     glb_etype = 16'h8808, glb_opcode = 16'h0001;
   logic [15:0]     pri_etype = 16'h8808, pri_opcode = 16'h0101;
   logic            tx_valid, tx_last;
   logic [DW-1:0]   tx_data;
   logic [8:0]      slot_sent;

   always_comb for (int i = 0; i < 9; i++) begin
      slot_quanta[16*i +: 16]  = q[i];
      slot_refresh[TW*i +: TW] = rf[i];
   end

   pause_tx_sched #(.DATA_W(DW), .TMR_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .slot_en(slot_en), .resend(resend),
      .slot_quanta(slot_quanta), .slot_refresh(slot_refresh),
      .glb_da(glb_da), .glb_sa(glb_sa), .glb_etype(glb_etype), .glb_opcode(glb_opcode),
      .pri_da(pri_da), .pri_sa(pri_sa), .pri_etype(pri_etype), .pri_opcode(pri_opcode),
      .user_busy(user_busy), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .slot_sent(slot_sent));

   int    n_chk = 0, n_bad = 0, vcount = 0;
   string cur_req = "R1";
   logic [8:0] slog [$];

   // behavioural reference
   bit         m_pend [9];
   int         m_wait [9];
   bit         m_tx = 0;
   int         m_beat = 0;
   logic [7:0] m_fr [64];
   logic [8:0] m_cov = '0, m_sent = '0;

   task automatic build(input bit glb, input logic [7:0] pm);
      logic [47:0] da, sa; logic [15:0] et, op;
      da = glb ? glb_da : pri_da;   sa = glb ? glb_sa : pri_sa;
      et = glb ? glb_etype : pri_etype; op = glb ? glb_opcode : pri_opcode;
      for (int k = 0; k < 64; k++) m_fr[k] = 8'h00;
      for (int k = 0; k < 6; k++) begin
         m_fr[k]   = 8'((da >> (40 - 8*k)) & 48'hFF);
         m_fr[6+k] = 8'((sa >> (40 - 8*k)) & 48'hFF);
      end
      m_fr[12] = et / 256; m_fr[13] = et % 256;
      m_fr[14] = op / 256; m_fr[15] = op % 256;
      if (glb) begin
         m_fr[16] = q[8] / 256; m_fr[17] = q[8] % 256;
      end else begin
         m_fr[17] = pm;
         for (int p = 0; p < 8; p++) if (pm[p]) begin
            m_fr[18+2*p] = q[p] / 256; m_fr[19+2*p] = q[p] % 256;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 9; i++) begin m_pend[i] = 0; m_wait[i] = 0; end
         m_tx = 0; m_beat = 0; m_cov = '0; m_sent = '0;
      end else begin
         logic [8:0] a; logic [7:0] pm; bit glb, fin, go;
         a   = slot_req & slot_en;
         glb = m_pend[8] && a[8];
         for (int p = 0; p < 8; p++) pm[p] = m_pend[p] && a[p];
         fin = m_tx && tx_ready && (m_beat == NB-1);
         go  = !m_tx && !user_busy && (glb || pm != 0);
         m_sent = fin ? m_cov : 9'h000;
         for (int i = 0; i < 9; i++) begin
            if (resend) begin m_pend[i] = a[i]; m_wait[i] = 0; end
            else if (fin && m_cov[i]) begin m_pend[i] = 0; m_wait[i] = int'(rf[i]) + 1; end
            else begin
               m_pend[i] = a[i] && (m_pend[i] || m_wait[i] == 0);
               if (m_wait[i] > 0) m_wait[i]--;
            end
         end
         if (go) begin
            build(glb, pm);
            m_cov = glb ? 9'h100 : {1'b0, pm};
            m_tx = 1; m_beat = 0;
         end else if (m_tx && tx_ready) begin
            if (fin) m_tx = 0; else m_beat++;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      logic [63:0] ed;
      for (int m = 0; m < 8; m++) ed[8*m +: 8] = m_fr[8*m_beat + m];
      check(tx_valid === m_tx, {cur_req, " tx_valid"}, 64'(tx_valid), 64'(m_tx));
      check(slot_sent === m_sent, {cur_req, " slot_sent"}, 64'(slot_sent), 64'(m_sent));
      if (m_tx) begin
         check(tx_last === (m_beat == NB-1), {cur_req, " tx_last"}, 64'(tx_last), 64'(m_beat == NB-1));
         check(tx_data === ed, {cur_req, " tx_data"}, tx_data, ed);
      end
      if (slot_sent != 0) slog.push_back(slot_sent);
      if (tx_valid) vcount++;
   end

   task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
   task automatic pulse_resend; @(negedge clk); resend = 1'b1; @(negedge clk); resend = 1'b0; endtask
   task automatic clean; slot_req = '0; pulse_resend(); cyc(12); slog.delete(); vcount = 0; endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cnt;
      for (int i = 0; i < 9; i++) begin q[i] = 16'h1000 + 16'(i * 16'h0111); rf[i] = 16'd1000; end
      // R1: reset
      cur_req = "R1";
      cyc(3);
      check(tx_valid === 1'b0 && slot_sent === 9'h000, "R1 reset outputs", {tx_valid, slot_sent}, 0);
      rst_n = 1'b1;
      cyc(5);
      check(vcount == 0, "R1 idle after reset", vcount, 0);

      // R2 / R8: repeating global frames
      cur_req = "R2";
      q[8] = 16'hABCD; rf[8] = 16'd30; slot_req = 9'h100;
      cyc(120);
      cnt = 0;
      foreach (slog[k]) if (slog[k] == 9'h100) cnt++;
      check(cnt >= 2, "R8 global repeats", cnt, 2);
      check(cnt == slog.size(), "R2 only global frames", slog.size(), cnt);
      clean();

      // R3 / R4 / R7: merged priority frame, slot 6 disabled
      cur_req = "R3";
      slot_en = 9'h1BF; slot_req = 9'h052;
      cyc(40);
      check(slog.size() == 1, "R3 one merged frame", slog.size(), 1);
      if (slog.size() > 0) begin
         check(slog[0] == 9'h012, "R7 covered slots", slog[0], 9'h012);
         check(slog[0][6] == 1'b0, "R4 disabled slot absent", slog[0], 9'h012);
      end
      slot_en = 9'h1FF;
      clean();

      // R6: global before priority
      cur_req = "R6";
      slot_req = 9'h181;
      cyc(40);
      check(slog.size() == 2, "R6 two frames", slog.size(), 2);
      if (slog.size() == 2) begin
         check(slog[0] == 9'h100, "R6 global first", slog[0], 9'h100);
         check(slog[1] == 9'h081, "R6 priority second", slog[1], 9'h081);
      end
      clean();

      // R5: user frame in flight
      cur_req = "R5";
      user_busy = 1'b1; slot_req = 9'h004;
      cyc(30);
      check(vcount == 0, "R5 held off while busy", vcount, 0);
      user_busy = 1'b0;
      cyc(20);
      check(slog.size() == 1 && slog[0] == 9'h004, "R5 sent after busy", slog.size(), 1);
      clean();

      // R10: backpressure and busy toggling
      cur_req = "R10";
      rf[3] = 16'd10; rf[8] = 16'd10; slot_req = 9'h108;
      begin
         logic [7:0] lf = 8'hA5;
         for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            tx_ready  = lf[0] | lf[2];
            user_busy = lf[1] & lf[6];
         end
      end
      tx_ready = 1'b1; user_busy = 1'b0;
      check(slog.size() >= 2, "R10 frames under stall", slog.size(), 2);
      clean();

      // R9: resend cuts a long refresh short
      cur_req = "R9";
      rf[5] = 16'd1000; slot_req = 9'h020;
      cyc(20);
      check(slog.size() == 1, "R9 first frame", slog.size(), 1);
      pulse_resend();
      cyc(20);
      check(slog.size() == 2, "R9 resent after strobe", slog.size(), 2);
      clean();

      // R8: zero refresh interval
      cur_req = "R8";
      rf[0] = 16'd0; slot_req = 9'h001;
      cyc(60);
      check(slog.size() >= 4, "R8 zero refresh repeats", slog.size(), 4);
      slot_req = '0;
      cyc(10);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule